// File: doc/BRIEF.md
# Ethernet Link Bring-Up Controller

This controller sequences how a twisted-pair Ethernet physical layer brings its link up. After reset, after a wake from sleep, or after any loss of link, it passes through a start state. From there a single enable input chooses the path. With the enable clear, the controller waits in a forced state for line activity that matches the speed it has been told to use. With the enable set, it waits in a detect state. In that state, negotiation and parallel detection run side by side, and parallel detection watches for both 10 Mb/s link pulses and 100 Mb/s idle.

The negotiation page exchange, pulse detection and symbol decoding live in other blocks, and reach this one as single-cycle strobes. The resolved speed selects the data-path clock rate: 25 MHz at 100 Mb/s and 2.5 MHz at 10 Mb/s. If nothing is detected, a listen timer expires, and the controller then asks the negotiation logic to start over.

Top module: `link_setup_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `state_onehot`=4'b0001 (start), with `link_up`, `speed_100`, `full_duplex` and `restart_an` all 0.
- R2: From start, absent `link_fail` and `wake`, the next state is detect (4'b0100) when `an_enable` is 1 and forced (4'b0010) when it is 0.
- R3: In forced, the link comes up (state 4'b1000, `link_up`=1) on the clock after the matching activity strobe: `idle_100_seen` when `force_100`=1, `pulse_10_seen` when it is 0. `speed_100` and `full_duplex` then take the forced values. The other strobe is ignored, and the state stays forced.
- R4: In detect, `an_done` brings the link up on the next clock with `speed_100`=`an_speed_100` and `full_duplex`=`an_full`. It wins over any parallel-detect strobe in the same cycle.
- R5: In detect without `an_done`, `idle_100_seen` brings the link up at 100 Mb/s half duplex, and `pulse_10_seen` brings it up at 10 Mb/s half duplex. If both strobes arrive together, idle wins.
- R6: In detect with no event, `restart_an` is high for exactly one cycle after every LISTEN_CYCLES cycles spent in detect, and the state remains detect.
- R7: `link_fail` in any state gives start with `link_up`=0 on the next clock.
- R8: `wake` in any state gives start on the next clock.
- R9: In forced, detect or link-up, an `an_enable` value that differs from the path chosen at start sends the controller to start on the next clock.
- R10: `state_onehot` always has exactly one bit set: bit 0 is start, bit 1 forced, bit 2 detect, bit 3 link-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| an_enable | input | 1 | 1 = negotiate and parallel-detect, 0 = forced settings |
| force_100 | input | 1 | Forced speed, 1 = 100 Mb/s |
| force_full | input | 1 | Forced duplex, 1 = full |
| an_done | input | 1 | Strobe: negotiation finished |
| an_speed_100 | input | 1 | Negotiated speed, valid with `an_done` |
| an_full | input | 1 | Negotiated duplex, valid with `an_done` |
| pulse_10_seen | input | 1 | Strobe: 10 Mb/s link pulses detected |
| idle_100_seen | input | 1 | Strobe: 100 Mb/s idle detected |
| link_fail | input | 1 | Strobe: link lost |
| wake | input | 1 | Strobe: leaving sleep |
| link_up | output | 1 | Link established |
| speed_100 | output | 1 | Resolved speed, 1 = 100 Mb/s (selects 25 MHz vs 2.5 MHz data clock) |
| full_duplex | output | 1 | Resolved duplex |
| restart_an | output | 1 | One-cycle request to restart negotiation |
| state_onehot | output | 4 | Current state, one-hot |

## Verification
The bench sweeps every combination of negotiation-done, idle, pulse and negotiated speed and duplex in detect. A design with the priorities swapped would report a parallel-detect speed in place of the negotiated one. It also sweeps every forced speed and duplex against every activity pattern. Here a wrong design would bring the link up on the wrong kind of activity. The listen timer is checked over two full periods, which catches a restart pulse that is one cycle early or late, or that stays high. The bench also covers link failure, wake, and flipping the enable in each state, where a faulty controller would keep the link up or skip the start state.

// File: rtl/link_setup_pkg.sv
`timescale 1ns/1ps
package link_setup_pkg;

    localparam int NUM_STATES = 4;

    typedef enum logic [NUM_STATES-1:0] {
        ST_START  = 4'b0001,
        ST_FORCE  = 4'b0010,
        ST_DETECT = 4'b0100,
        ST_UP     = 4'b1000
    } ls_state_e;

    typedef struct packed {
        ls_state_e state;
        logic      link_up;
        logic      speed_100;
        logic      full_duplex;
        logic      restart;
        logic      auto_mode;
    } ls_ctl_t;

endpackage

// File: rtl/ls_listen_timer.sv
`timescale 1ns/1ps
module ls_listen_timer #(
    parameter int LISTEN_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LISTEN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(LISTEN_CYCLES - 1);

    logic [CW-1:0] count_d, count_q;

    always_comb begin
        expired = run && (count_q == LAST);
        if (!run || expired) begin
            count_d = '0;
        end else begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end
endmodule

// File: rtl/ls_resolver.sv
`timescale 1ns/1ps
module ls_resolver (
    input  logic auto_mode,
    input  logic an_done,
    input  logic an_speed_100,
    input  logic an_full,
    input  logic pulse_10_seen,
    input  logic idle_100_seen,
    input  logic force_100,
    input  logic force_full,
    output logic hit,
    output logic res_100,
    output logic res_full
);
    always_comb begin
        hit      = 1'b0;
        res_100  = 1'b0;
        res_full = 1'b0;
        if (auto_mode) begin
            if (an_done) begin
                hit      = 1'b1;
                res_100  = an_speed_100;
                res_full = an_full;
            end else if (idle_100_seen) begin
                hit     = 1'b1;
                res_100 = 1'b1;
            end else if (pulse_10_seen) begin
                hit = 1'b1;
            end
        end else begin
            hit      = force_100 ? idle_100_seen : pulse_10_seen;
            res_100  = force_100;
            res_full = force_full;
        end
    end
endmodule

// File: rtl/link_setup_ctrl.sv
`timescale 1ns/1ps
module link_setup_ctrl
    import link_setup_pkg::*;
#(
    parameter int LISTEN_CYCLES = 1024
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  an_enable,
    input  logic                  force_100,
    input  logic                  force_full,
    input  logic                  an_done,
    input  logic                  an_speed_100,
    input  logic                  an_full,
    input  logic                  pulse_10_seen,
    input  logic                  idle_100_seen,
    input  logic                  link_fail,
    input  logic                  wake,
    output logic                  link_up,
    output logic                  speed_100,
    output logic                  full_duplex,
    output logic                  restart_an,
    output logic [NUM_STATES-1:0] state_onehot
);
    ls_ctl_t ctl_d, ctl_q;
    logic    hit, res_100, res_full;
    logic    abort, mode_flip, timer_run, timer_expired;

    assign abort     = link_fail || wake;
    assign mode_flip = (an_enable != ctl_q.auto_mode);
    assign timer_run = (ctl_q.state == ST_DETECT) && !abort && !mode_flip && !hit;

    ls_resolver u_resolve (
        .auto_mode     (ctl_q.state == ST_DETECT),
        .an_done       (an_done),
        .an_speed_100  (an_speed_100),
        .an_full       (an_full),
        .pulse_10_seen (pulse_10_seen),
        .idle_100_seen (idle_100_seen),
        .force_100     (force_100),
        .force_full    (force_full),
        .hit           (hit),
        .res_100       (res_100),
        .res_full      (res_full)
    );

    ls_listen_timer #(.LISTEN_CYCLES(LISTEN_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (timer_run),
        .expired (timer_expired)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.restart = 1'b0;
        if (abort) begin
            ctl_d.state       = ST_START;
            ctl_d.link_up     = 1'b0;
            ctl_d.speed_100   = 1'b0;
            ctl_d.full_duplex = 1'b0;
        end else begin
            unique case (ctl_q.state)
                ST_START: begin
                    ctl_d.auto_mode = an_enable;
                    ctl_d.state     = an_enable ? ST_DETECT : ST_FORCE;
                end
                ST_FORCE, ST_DETECT: begin
                    if (mode_flip) begin
                        ctl_d.state = ST_START;
                    end else if (hit) begin
                        ctl_d.state       = ST_UP;
                        ctl_d.link_up     = 1'b1;
                        ctl_d.speed_100   = res_100;
                        ctl_d.full_duplex = res_full;
                    end else if (timer_expired) begin
                        ctl_d.restart = 1'b1;
                    end
                end
                ST_UP: begin
                    if (mode_flip) begin
                        ctl_d.state       = ST_START;
                        ctl_d.link_up     = 1'b0;
                        ctl_d.speed_100   = 1'b0;
                        ctl_d.full_duplex = 1'b0;
                    end
                end
                default: begin
                    ctl_d.state   = ST_START;
                    ctl_d.link_up = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.state       <= ST_START;
            ctl_q.link_up     <= 1'b0;
            ctl_q.speed_100   <= 1'b0;
            ctl_q.full_duplex <= 1'b0;
            ctl_q.restart     <= 1'b0;
            ctl_q.auto_mode   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign link_up      = ctl_q.link_up;
    assign speed_100    = ctl_q.speed_100;
    assign full_duplex  = ctl_q.full_duplex;
    assign restart_an   = ctl_q.restart;
    assign state_onehot = ctl_q.state;
endmodule

// File: rtl/link_setup_chk.sv
`timescale 1ns/1ps
module link_setup_chk #(
    parameter int LISTEN_CYCLES = 1024
) (
    input logic       clk,
    input logic       rst,
    input logic       an_enable,
    input logic       link_fail,
    input logic       wake,
    input logic       link_up,
    input logic       restart_an,
    input logic [3:0] state_onehot
);
    localparam logic [3:0] S_START  = 4'b0001;
    localparam logic [3:0] S_FORCE  = 4'b0010;
    localparam logic [3:0] S_DETECT = 4'b0100;
    localparam logic [3:0] S_UP     = 4'b1000;

    int quiet_q;

    always_ff @(posedge clk) begin
        if (rst || state_onehot != S_DETECT || restart_an) begin
            quiet_q <= 0;
        end else begin
            quiet_q <= quiet_q + 1;
        end
    end

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(state_onehot) == 1); // R10

    AST_START_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (state_onehot == S_START && !link_fail && !wake)
        |=> state_onehot == ($past(an_enable) ? S_DETECT : S_FORCE)); // R2

    AST_UP_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up) |-> state_onehot == S_UP); // R3

    AST_FAIL_DROPS: assert property (@(posedge clk) disable iff (rst)
        link_fail |=> (state_onehot == S_START && !link_up)); // R7

    AST_WAKE_START: assert property (@(posedge clk) disable iff (rst)
        wake |=> state_onehot == S_START); // R8

    AST_RESTART_ONE: assert property (@(posedge clk) disable iff (rst)
        restart_an |=> !restart_an); // R6

    AST_RESTART_IN_DETECT: assert property (@(posedge clk) disable iff (rst)
        restart_an |-> state_onehot == S_DETECT); // R6

    AST_LISTEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        quiet_q <= LISTEN_CYCLES); // R6
endmodule

bind link_setup_ctrl link_setup_chk #(.LISTEN_CYCLES(LISTEN_CYCLES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .an_enable    (an_enable),
    .link_fail    (link_fail),
    .wake         (wake),
    .link_up      (link_up),
    .restart_an   (restart_an),
    .state_onehot (state_onehot)
);

// File: tb/sim_link_setup_ctrl.sv
`timescale 1ns/1ps
module sim_link_setup_ctrl;
    localparam int L = 5;
    localparam logic [3:0] S_START  = 4'b0001;
    localparam logic [3:0] S_FORCE  = 4'b0010;
    localparam logic [3:0] S_DETECT = 4'b0100;
    localparam logic [3:0] S_UP     = 4'b1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic an_enable = 1'b0, force_100 = 1'b0, force_full = 1'b0;
    logic an_done = 1'b0, an_speed_100 = 1'b0, an_full = 1'b0;
    logic pulse_10_seen = 1'b0, idle_100_seen = 1'b0, link_fail = 1'b0, wake = 1'b0;
    logic link_up, speed_100, full_duplex, restart_an;
    logic [3:0] state_onehot;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    link_setup_ctrl #(.LISTEN_CYCLES(L)) u0 (
        .clk(clk), .rst(rst), .an_enable(an_enable), .force_100(force_100),
        .force_full(force_full), .an_done(an_done), .an_speed_100(an_speed_100),
        .an_full(an_full), .pulse_10_seen(pulse_10_seen), .idle_100_seen(idle_100_seen),
        .link_fail(link_fail), .wake(wake), .link_up(link_up), .speed_100(speed_100),
        .full_duplex(full_duplex), .restart_an(restart_an), .state_onehot(state_onehot)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_events();
        an_done = 1'b0; pulse_10_seen = 1'b0; idle_100_seen = 1'b0;
        link_fail = 1'b0; wake = 1'b0;
    endtask

    // Ends at a negedge with the controller in its listen state.
    task automatic start_link(input logic en);
        @(negedge clk);
        rst = 1'b1;
        an_enable = en;
        clear_events();
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 state", state_onehot, S_START);
        chk("R1 link_up", link_up, 0);
        chk("R1 restart", restart_an, 0);
        chk("R1 speed/duplex", {speed_100, full_duplex}, 0);

        // R2: routing from start
        start_link(1'b1);
        chk("R2 to detect", state_onehot, S_DETECT);
        start_link(1'b0);
        chk("R2 to forced", state_onehot, S_FORCE);

        // R4/R5: sweep of detect events
        for (int c = 0; c < 32; c++) begin
            logic e_up, e_100, e_full;
            start_link(1'b1);
            an_done = c[0]; idle_100_seen = c[1]; pulse_10_seen = c[2];
            an_speed_100 = c[3]; an_full = c[4];
            @(negedge clk);
            clear_events();
            if (c[0]) begin
                e_up = 1; e_100 = c[3]; e_full = c[4];
            end else if (c[1]) begin
                e_up = 1; e_100 = 1; e_full = 0;
            end else if (c[2]) begin
                e_up = 1; e_100 = 0; e_full = 0;
            end else begin
                e_up = 0; e_100 = 0; e_full = 0;
            end
            chk("R4 R5 state", state_onehot, e_up ? S_UP : S_DETECT);
            chk("R4 R5 link_up", link_up, e_up);
            chk("R4 R5 speed_100", speed_100, e_100);
            chk("R4 R5 full_duplex", full_duplex, e_full);
        end

        // R3: sweep of forced settings against activity
        for (int f = 0; f < 4; f++) begin
            for (int ev = 0; ev < 4; ev++) begin
                logic e_up;
                force_100 = f[1]; force_full = f[0];
                start_link(1'b0);
                pulse_10_seen = ev[0]; idle_100_seen = ev[1];
                @(negedge clk);
                clear_events();
                e_up = f[1] ? ev[1] : ev[0];
                chk("R3 state", state_onehot, e_up ? S_UP : S_FORCE);
                chk("R3 link_up", link_up, e_up);
                chk("R3 speed/duplex", {speed_100, full_duplex},
                    e_up ? {f[1], f[0]} : 2'b00);
            end
        end

        // R6: listen timer over two periods
        start_link(1'b1);
        for (int i = 0; i <= 2 * L + 1; i++) begin
            chk("R6 restart", restart_an, (i == L || i == 2 * L) ? 1 : 0);
            chk("R6 state", state_onehot, S_DETECT);
            @(negedge clk);
        end

        // R7: link failure while up, and while detecting
        start_link(1'b1);
        idle_100_seen = 1'b1;
        @(negedge clk);
        clear_events();
        chk("R7 pre up", link_up, 1);
        link_fail = 1'b1;
        @(negedge clk);
        clear_events();
        chk("R7 state", state_onehot, S_START);
        chk("R7 link_up", link_up, 0);
        @(negedge clk);
        chk("R7 R2 back to detect", state_onehot, S_DETECT);
        link_fail = 1'b1; idle_100_seen = 1'b1;
        @(negedge clk);
        clear_events();
        chk("R7 fail beats idle", state_onehot, S_START);

        // R8: wake in forced and in link-up
        force_100 = 1'b0;
        start_link(1'b0);
        wake = 1'b1;
        @(negedge clk);
        clear_events();
        chk("R8 from forced", state_onehot, S_START);
        start_link(1'b1);
        an_done = 1'b1;
        @(negedge clk);
        clear_events();
        wake = 1'b1;
        @(negedge clk);
        clear_events();
        chk("R8 from up", state_onehot, S_START);
        chk("R8 link_up", link_up, 0);

        // R9: enable flip in link-up and in forced
        start_link(1'b1);
        an_done = 1'b1;
        @(negedge clk);
        clear_events();
        an_enable = 1'b0;
        @(negedge clk);
        chk("R9 up flip state", state_onehot, S_START);
        chk("R9 up flip link", link_up, 0);
        @(negedge clk);
        chk("R9 then forced", state_onehot, S_FORCE);
        an_enable = 1'b1;
        @(negedge clk);
        chk("R9 forced flip", state_onehot, S_START);
        @(negedge clk);
        chk("R9 then detect", state_onehot, S_DETECT);
        chk("R10 onehot", $countones(state_onehot), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule